// File: doc/BRIEF.md
# Single-Mode DMA Channel Sequencer with Page Extension

This block drives the transfers of one channel of a DMA controller in single mode. The channel's current address and current element count live inside the block. A one-cycle program strobe copies them from externally held base values. On each request the block decodes a mode byte, checks the controller-disable bit of a command byte and the channel's own mask bit, and then moves one element. It either runs a memory cycle on a request/acknowledge interface or, for a verify transfer, steps the counters without touching memory.

The physical address joins an 8-bit page value, placed above the 16-bit channel address, with that address. A word channel, chosen by a parameter, shifts its address left by one under the page and issues 16-bit cycles. When the count runs out, the block sets a terminal-count status bit, clears the request-pending bit and pulses a terminal-count output. It then either reloads the current registers from the base values or masks the channel.

The controller is a three-state machine. IDLE waits for a request that may start. IDLE goes to MEM when a memory write or memory read starts, and to STEP when a verify starts. MEM holds the memory request until the acknowledge arrives and then goes to STEP. STEP updates the counters and the status, and always returns to IDLE.

Top module: `dma_chan_seq`

## Requirements
- R1: After reset the current address and count are zero, the channel is masked, the status byte is zero, and `busy`, `mem_req` and `tc_pulse` are low.
- R2: A request starts nothing while bit 2 of `cmd_byte` is set or `chan_mask` is set; counters, memory interface and `busy` stay unchanged.
- R3: Operating mode is `mode_byte[7:6]`: 0 demand, 1 single, 2 block, 3 cascade. Only 1 runs; a request in any other mode is refused with no memory cycle and no counter change.
- R4: Transfer type is `mode_byte[3:2]`. With 0 (verify) the counters step but no memory cycle is issued. With 1 (write to memory) the cycle has `mem_we`=1. With 2 (read from memory) it has `mem_we`=0. With 3 the request is refused.
- R5: After each element the current count drops by one. The current address moves down by one when `mode_byte[5]` is 1 and up by one when it is 0, wrapping modulo 2^16.
- R6: A byte channel (`WIDE`=0) drives `mem_addr` = {page, current address} with `mem_be`=01. A word channel (`WIDE`=1) drives {page, current address[14:0], 0} with `mem_be`=11.
- R7: `mem_req` stays high with a stable `mem_addr` until `mem_ack`, and the counters do not change before the acknowledge.
- R8: On the element that brings the count to zero, status bit CHAN of `dma_stat` is set, bit CHAN+4 is cleared, and `tc_pulse` is high for exactly one cycle.
- R9: At terminal count with `mode_byte[4]`=1 the current address and count reload from `base_addr`/`base_cnt`. With it 0, `chan_mask` is set.
- R10: Status bit CHAN+4 (request pending) is set by any cycle with `req` high and cleared at terminal count. `prog` in IDLE loads the current registers from the base values and clears status bit CHAN.
- R11: A request with a current count of zero is refused.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_byte | input | 8 | Controller command byte; bit 2 disables transfers |
| mode_byte | input | 8 | Channel mode byte (operating mode, direction, auto-initialise, transfer type) |
| page | input | PW | Page value placed above the channel address |
| base_addr | input | AW | Base address copy |
| base_cnt | input | CW | Base element count copy |
| prog | input | 1 | Load current registers from base and clear terminal-count status |
| mask_wr | input | 1 | Write strobe for the channel mask bit |
| mask_din | input | 1 | Mask bit value to write |
| req | input | 1 | Channel request, one element per started request |
| mem_req | output | 1 | Memory cycle request |
| mem_we | output | 1 | 1 = write to memory, 0 = read from memory |
| mem_addr | output | PW+AW | Physical address |
| mem_be | output | 2 | Byte enables |
| mem_ack | input | 1 | Memory cycle acknowledge |
| cur_addr | output | AW | Current address |
| cur_cnt | output | CW | Current element count |
| chan_mask | output | 1 | Channel mask bit |
| dma_stat | output | 8 | Status: bit CHAN terminal count, bit CHAN+4 request pending |
| tc_pulse | output | 1 | One-cycle terminal-count pulse |
| busy | output | 1 | High while an element is in progress |

## Verification
A request sampled at a clock edge makes `busy` visible after that edge. For a memory type `mem_req` and `mem_addr` show there as well; for a verify, the counters update at the next edge. After the edge that sees `mem_ack`, one further edge (STEP) updates the counters, the status and `tc_pulse`. The bench therefore drives on falling edges and samples on falling edges. It walks each element until `busy` falls and checks the counters, mask, status and pulse at exactly that point. It checks `tc_pulse` low again one cycle later, and it holds off the acknowledge for two cycles to confirm that nothing moves early. Every combination of operating mode, direction, auto-initialise and transfer type is swept, on a byte and a word instance in lockstep, with start addresses that cross the 16-bit wrap.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;

    typedef enum logic [1:0] {
        OP_DEMAND  = 2'd0,
        OP_SINGLE  = 2'd1,
        OP_BLOCK   = 2'd2,
        OP_CASCADE = 2'd3
    } op_e;

    typedef enum logic [1:0] {
        XF_VERIFY = 2'd0,
        XF_WRITE  = 2'd1,
        XF_READ   = 2'd2,
        XF_BAD    = 2'd3
    } xfer_e;

    typedef struct packed {
        op_e   op;
        logic  down;
        logic  ainit;
        xfer_e xfer;
    } mode_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_MEM  = 2'd1,
        S_STEP = 2'd2
    } state_e;

endpackage

// File: rtl/dma_mode_dec.sv
module dma_mode_dec
    import dma_seq_pkg::*;
(
    input  logic [7:0] mode_byte,
    output mode_t      fields,
    output logic       runnable
);
    logic unused_mode_bits;
    assign unused_mode_bits = ^mode_byte[1:0];

    always_comb begin
        fields.op    = op_e'(mode_byte[7:6]);
        fields.down  = mode_byte[5];
        fields.ainit = mode_byte[4];
        fields.xfer  = xfer_e'(mode_byte[3:2]);
        runnable     = (fields.op == OP_SINGLE) && (fields.xfer != XF_BAD);
    end
endmodule

// File: rtl/dma_addr_form.sv
module dma_addr_form #(
    parameter int AW   = 16,
    parameter int PW   = 8,
    parameter bit WIDE = 1'b0
) (
    input  logic [PW-1:0]    page,
    input  logic [AW-1:0]    cur,
    output logic [PW+AW-1:0] phys,
    output logic [1:0]       be
);
    generate
        if (WIDE) begin : g_word
            logic unused_top_bit;
            assign unused_top_bit = cur[AW-1];
            assign phys = {page, cur[AW-2:0], 1'b0};
            assign be   = 2'b11;
        end else begin : g_byte
            assign phys = {page, cur};
            assign be   = 2'b01;
        end
    endgenerate
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
    import dma_seq_pkg::*;
#(
    parameter int AW   = 16,
    parameter int CW   = 16,
    parameter int PW   = 8,
    parameter bit WIDE = 1'b0,
    parameter int CHAN = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       cmd_byte,
    input  logic [7:0]       mode_byte,
    input  logic [PW-1:0]    page,
    input  logic [AW-1:0]    base_addr,
    input  logic [CW-1:0]    base_cnt,
    input  logic             prog,
    input  logic             mask_wr,
    input  logic             mask_din,
    input  logic             req,
    output logic             mem_req,
    output logic             mem_we,
    output logic [PW+AW-1:0] mem_addr,
    output logic [1:0]       mem_be,
    input  logic             mem_ack,
    output logic [AW-1:0]    cur_addr,
    output logic [CW-1:0]    cur_cnt,
    output logic             chan_mask,
    output logic [7:0]       dma_stat,
    output logic             tc_pulse,
    output logic             busy
);
    localparam int DIS_BIT  = 2;
    localparam int TC_BIT   = CHAN;
    localparam int PEND_BIT = CHAN + 4;

    state_e  state, nxt;
    mode_t   fields;
    logic    runnable;
    logic    start;
    logic    down_q, ainit_q, we_q;
    logic    st_tc, st_pend;
    logic    last_elem;
    logic [AW-1:0] stepped_addr;

    logic unused_cmd_bits;
    assign unused_cmd_bits = ^{cmd_byte[7:DIS_BIT+1], cmd_byte[DIS_BIT-1:0]};

    dma_mode_dec u_dec (
        .mode_byte (mode_byte),
        .fields    (fields),
        .runnable  (runnable)
    );

    dma_addr_form #(.AW(AW), .PW(PW), .WIDE(WIDE)) u_addr (
        .page (page),
        .cur  (cur_addr),
        .phys (mem_addr),
        .be   (mem_be)
    );

    assign start = (state == S_IDLE) && req && !cmd_byte[DIS_BIT] && !chan_mask
                   && runnable && (cur_cnt != '0);
    assign last_elem    = (cur_cnt == CW'(1));
    assign stepped_addr = down_q ? cur_addr - AW'(1) : cur_addr + AW'(1);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: if (start) nxt = (fields.xfer == XF_VERIFY) ? S_STEP : S_MEM;
            S_MEM:  if (mem_ack) nxt = S_STEP;
            S_STEP: nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        mem_req = (state == S_MEM);
        mem_we  = (state == S_MEM) && we_q;
        busy    = (state != S_IDLE);
    end

    // channel registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            cur_cnt   <= '0;
            chan_mask <= 1'b1;
            st_tc     <= 1'b0;
            st_pend   <= 1'b0;
            tc_pulse  <= 1'b0;
            down_q    <= 1'b0;
            ainit_q   <= 1'b0;
            we_q      <= 1'b0;
        end else begin
            tc_pulse <= 1'b0;
            if (req)     st_pend   <= 1'b1;
            if (mask_wr) chan_mask <= mask_din;
            if (state == S_IDLE && prog) begin
                cur_addr <= base_addr;
                cur_cnt  <= base_cnt;
                st_tc    <= 1'b0;
            end
            if (start) begin
                down_q  <= fields.down;
                ainit_q <= fields.ainit;
                we_q    <= (fields.xfer == XF_WRITE);
            end
            if (state == S_STEP) begin
                if (last_elem) begin
                    tc_pulse <= 1'b1;
                    st_tc    <= 1'b1;
                    st_pend  <= 1'b0;
                    if (ainit_q) begin
                        cur_addr <= base_addr;
                        cur_cnt  <= base_cnt;
                    end else begin
                        cur_addr  <= stepped_addr;
                        cur_cnt   <= '0;
                        chan_mask <= 1'b1;
                    end
                end else begin
                    cur_addr <= stepped_addr;
                    cur_cnt  <= cur_cnt - CW'(1);
                end
            end
        end
    end

    always_comb begin
        dma_stat           = '0;
        dma_stat[TC_BIT]   = st_tc;
        dma_stat[PEND_BIT] = st_pend;
    end

    // R7: request held with stable address until acknowledged
    a_r7_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(cur_cnt)));

    // R2: a masked or disabled idle channel stays idle
    a_r2_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && (chan_mask || cmd_byte[DIS_BIT])) |=> !busy);

    // R5: a non-final element lowers the count by one
    a_r5_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_STEP && !last_elem) |=> (cur_cnt == $past(cur_cnt) - CW'(1)));

    // R8: terminal-count pulse is a single cycle and matches status
    a_r8_tc_single: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |=> !tc_pulse);
    a_r8_tc_status: assert property (@(posedge clk) disable iff (!rst_n)
        tc_pulse |-> (dma_stat[TC_BIT] && !dma_stat[PEND_BIT]));

    // R9: reload or mask at terminal count
    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && ainit_q) |-> (cur_cnt == $past(base_cnt)));
    a_r9_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (tc_pulse && !ainit_q) |-> (chan_mask && cur_cnt == '0));
endmodule

// File: tb/test_dma_chan_seq.sv
module test_dma_chan_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cmd_byte = 8'h00;
    logic [7:0]  mode_byte = 8'h00;
    logic [7:0]  page = 8'h00;
    logic [15:0] base_addr = 16'h0000;
    logic [15:0] base_cnt = 16'h0000;
    logic        prog = 1'b0, mask_wr = 1'b0, mask_din = 1'b0, req = 1'b0, mem_ack = 1'b0;

    logic        mem_req_b, mem_we_b, mask_b, tc_b, busy_b;
    logic [23:0] mem_addr_b;
    logic [1:0]  mem_be_b;
    logic [15:0] cur_addr_b, cur_cnt_b;
    logic [7:0]  stat_b;

    logic        mem_req_w, mem_we_w, mask_w, tc_w, busy_w;
    logic [23:0] mem_addr_w;
    logic [1:0]  mem_be_w;
    logic [15:0] cur_addr_w, cur_cnt_w;
    logic [7:0]  stat_w;

    int tests = 0, fails = 0;
    logic [15:0] exp_addr, exp_cnt;
    logic exp_mask, exp_tc, exp_pend;
    bit cur_ai, cur_dn;

    always #10 clk = ~clk;

    dma_chan_seq #(.WIDE(1'b0), .CHAN(1)) i_dma_chan_seq (
        .clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte), .mode_byte(mode_byte), .page(page),
        .base_addr(base_addr), .base_cnt(base_cnt), .prog(prog), .mask_wr(mask_wr),
        .mask_din(mask_din), .req(req), .mem_req(mem_req_b), .mem_we(mem_we_b),
        .mem_addr(mem_addr_b), .mem_be(mem_be_b), .mem_ack(mem_ack), .cur_addr(cur_addr_b),
        .cur_cnt(cur_cnt_b), .chan_mask(mask_b), .dma_stat(stat_b), .tc_pulse(tc_b), .busy(busy_b));

    dma_chan_seq #(.WIDE(1'b1), .CHAN(3)) i_dma_chan_seq_word (
        .clk(clk), .rst_n(rst_n), .cmd_byte(cmd_byte), .mode_byte(mode_byte), .page(page),
        .base_addr(base_addr), .base_cnt(base_cnt), .prog(prog), .mask_wr(mask_wr),
        .mask_din(mask_din), .req(req), .mem_req(mem_req_w), .mem_we(mem_we_w),
        .mem_addr(mem_addr_w), .mem_be(mem_be_w), .mem_ack(mem_ack), .cur_addr(cur_addr_w),
        .cur_cnt(cur_cnt_w), .chan_mask(mask_w), .dma_stat(stat_w), .tc_pulse(tc_w), .busy(busy_w));

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] stat_exp(input int ch);
        logic [7:0] s = 8'h00;
        s[ch] = exp_tc;
        s[ch+4] = exp_pend;
        return s;
    endfunction

    task automatic check_state(input string tag);
        chk({tag, " R5 addr byte"}, cur_addr_b, exp_addr);
        chk({tag, " R5 addr word"}, cur_addr_w, exp_addr);
        chk({tag, " R5 cnt"}, {cur_cnt_w, cur_cnt_b}, {exp_cnt, exp_cnt});
        chk({tag, " R9 mask"}, {mask_w, mask_b}, {exp_mask, exp_mask});
        chk({tag, " R8 R10 stat byte"}, stat_b, stat_exp(1));
        chk({tag, " R8 R10 stat word"}, stat_w, stat_exp(3));
    endtask

    task automatic prog_chan(input logic [15:0] a, input logic [15:0] c);
        @(negedge clk);
        base_addr = a; base_cnt = c; prog = 1'b1; mask_wr = 1'b1; mask_din = 1'b0;
        @(negedge clk);
        prog = 1'b0; mask_wr = 1'b0;
        exp_addr = a; exp_cnt = c; exp_mask = 1'b0; exp_tc = 1'b0;
        check_state("R10 prog");
    endtask

    task automatic elem(input string tag, input bit run, input bit is_mem, input bit is_wr);
        int guard = 0;
        bit saw_mem = 1'b0;
        bit tcnow = 1'b0;
        @(negedge clk);
        req = 1'b1; exp_pend = 1'b1;
        @(negedge clk);
        req = 1'b0;
        chk({tag, " busy"}, {busy_w, busy_b}, {run, run});
        while ((busy_b || busy_w) && guard < 50) begin
            guard++;
            if (mem_req_b) begin
                saw_mem = 1'b1;
                chk("R6 byte addr", mem_addr_b, {page, exp_addr});
                chk("R6 word addr", mem_addr_w, {page, exp_addr[14:0], 1'b0});
                chk("R6 be", {mem_be_w, mem_be_b}, 4'b1101);
                chk("R4 we", {mem_we_w, mem_we_b}, {is_wr, is_wr});
                for (int k = 0; k < 2; k++) begin
                    @(negedge clk);
                    chk("R7 held", {mem_req_w, mem_req_b}, 2'b11);
                    chk("R7 no early step", cur_cnt_b, exp_cnt);
                    chk("R7 addr stable", mem_addr_b, {page, exp_addr});
                end
                mem_ack = 1'b1;
                @(negedge clk);
                mem_ack = 1'b0;
            end else begin
                @(negedge clk);
            end
        end
        chk({tag, " R4 mem cycle"}, saw_mem, run && is_mem);
        if (run) begin
            exp_cnt = exp_cnt - 16'd1;
            exp_addr = cur_dn ? exp_addr - 16'd1 : exp_addr + 16'd1;
            if (exp_cnt == 16'd0) begin
                tcnow = 1'b1; exp_tc = 1'b1; exp_pend = 1'b0;
                if (cur_ai) begin exp_addr = base_addr; exp_cnt = base_cnt; end
                else exp_mask = 1'b1;
            end
        end
        check_state(tag);
        chk({tag, " R8 tc pulse"}, {tc_w, tc_b}, {tcnow, tcnow});
        @(negedge clk);
        chk({tag, " R8 pulse one cycle"}, {tc_w, tc_b}, 2'b00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        exp_addr = 0; exp_cnt = 0; exp_mask = 1; exp_tc = 0; exp_pend = 0;
        cur_ai = 0; cur_dn = 0;
        check_state("R1 reset");
        chk("R1 idle outputs", {busy_b, mem_req_b, tc_b, busy_w, mem_req_w, tc_w}, 6'b0);

        // R2: mask and disable refuse
        page = 8'h12;
        mode_byte = {2'd1, 1'b0, 1'b0, 2'd1, 2'b00};
        prog_chan(16'h1000, 16'd5);
        @(negedge clk); mask_wr = 1'b1; mask_din = 1'b1;
        @(negedge clk); mask_wr = 1'b0; exp_mask = 1'b1;
        elem("R2 masked", 1'b0, 1'b1, 1'b1);
        @(negedge clk); mask_wr = 1'b1; mask_din = 1'b0;
        @(negedge clk); mask_wr = 1'b0; exp_mask = 1'b0;
        cmd_byte = 8'h04;
        elem("R2 disabled", 1'b0, 1'b1, 1'b1);
        cmd_byte = 8'hFB;
        elem("R2 other cmd bits", 1'b1, 1'b1, 1'b1);
        cmd_byte = 8'h00;

        // R11: zero count refused
        prog_chan(16'h2222, 16'd0);
        elem("R11 zero count", 1'b0, 1'b1, 1'b1);

        // Sweep of every mode combination
        for (int op = 0; op < 4; op++) begin
            for (int dn = 0; dn < 2; dn++) begin
                for (int ai = 0; ai < 2; ai++) begin
                    for (int xf = 0; xf < 4; xf++) begin
                        bit runs;
                        mode_byte = {op[1:0], dn[0], ai[0], xf[1:0], 2'b00};
                        cur_ai = ai[0]; cur_dn = dn[0];
                        page = 8'h40 + 8'(op * 16 + dn * 8 + ai * 4 + xf);
                        runs = (op == 1) && (xf != 3);
                        prog_chan(dn[0] ? 16'h0001 : 16'hFFFE, 16'd3);
                        for (int e = 0; e < 4; e++) begin
                            bit r;
                            r = runs && !exp_mask;
                            elem(runs ? "R3 R4 R5 R9 single" : "R3 R4 refused",
                                 r, xf != 0, xf == 1);
                        end
                    end
                end
            end
        end

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        tests++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule